// File: doc/BRIEF.md
# Polyphase FIR Front End for a 32-Point Transform

This block is the weighted-overlap filter that sits in front of a 32-point transform. The filter has eight taps. Each tap looks one full frame of 32 samples further into the past than the tap before it. Two independent complex streams enter together, one sample of each per clock. Every stream word is packed with the real part in its upper half and the imaginary part in its lower half. That gives four scalar lanes, and all four are filtered with the same coefficients.

The coefficient set is a ROM of 8 x 32 entries, computed at elaboration. A rotation counter picks the entry for each tap on each clock, and it returns to zero every 32 clocks. A sync pulse, given one clock ahead of the first frame sample, restarts the rotation. The eight tap products of each lane are summed at full precision. The sum is then shifted down with half-up rounding and clipped to the output width. A matching sync pulse comes out one clock ahead of the first filtered sample.

Top module: `pfb_polyphase_fir`

## Requirements
- R1: Input words carry the real part in bits [2*IW-1:IW] and the imaginary part in bits [IW-1:0]. Output words carry the real part in bits [2*OW-1:OW] and the imaginary part in bits [OW-1:0]. Stream A maps only to dout_a and stream B only to dout_b.
- R2: The sample seen by tap t (t = 0..7) is the lane input from t*32 clocks earlier, counted in samples. Samples from before reset release count as zero.
- R3: A rotation index r, running 0..31, advances by one every clock and wraps to 0. Tap t at index r uses coefficient c(j) = ((29*j + 11) mod 255) - 127, where j = t*32 + 31 - r. The first sample of a frame therefore meets the highest argument of each tap's slice.
- R4: Extra sync pulses that fall exactly where the rotation would wrap anyway leave the output unchanged.
- R5: The real and imaginary lanes of both streams use the identical coefficient for a given tap and index.
- R6: Each output is floor((S + 2^(SHIFT-1)) / 2^SHIFT), with SHIFT = 1 by default, where S is the exact sum over the taps of sample times coefficient. The output for the sample presented in clock k appears after the second rising edge that follows.
- R7: A rounded value above 2^(OW-1)-1 is output as 2^(OW-1)-1. A rounded value below -2^(OW-1) is output as -2^(OW-1).
- R8: sync_out is sync_in delayed by two clocks. It is therefore high one clock before the first output of the frame that sync_in announced.
- R9: While rst_n is low, dout_a, dout_b and sync_out are zero, and the delay history is cleared.
- R10: A sync pulse at any rotation index makes the next clock's sample use index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame warning, high one clock before the first sample of a frame |
| din_a | input | 2*IW | Stream A, real part in upper half and imaginary part in lower half |
| din_b | input | 2*IW | Stream B, packed the same way |
| sync_out | output | 1 | Frame warning for the filtered output |
| dout_a | output | 2*OW | Filtered stream A, real part in upper half |
| dout_b | output | 2*OW | Filtered stream B, real part in upper half |

## Verification
The bench builds two copies of the block that share all inputs. The first uses the defaults (OW = 18, SHIFT = 1). Its sums can never reach the output limits, so it exposes exact half-up rounding, including odd sums that land on ties. The second is built with OW = 12, where full-scale inputs drive the sums well past both limits, which brings the clipping in both directions within reach. An impulse followed by more than eight frames of silence reads out every coefficient of every tap in rotation order.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // Window value at argument index j; a deterministic placeholder pattern
  // spanning the signed range of a cw-bit coefficient.
  function automatic int coef_value(input int j, input int cw);
    int span;
    int mid;
    span = (1 << cw) - 1;
    mid  = (1 << (cw - 1)) - 1;
    return ((29 * j + 11) % span) - mid;
  endfunction

  // ROM address -> argument index: each tap slice is stored in descending
  // argument order so rotation index 0 meets the highest argument.
  function automatic int coef_arg(input int addr, input int n);
    return (addr / n) * n + (n - 1 - (addr % n));
  endfunction

endpackage

// File: rtl/pfb_delay_line.sv
module pfb_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;

  // The slot about to be overwritten holds the word from DEPTH clocks ago.
  assign dout = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[ptr] <= din;
      ptr      <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
    end
  end
endmodule

// File: rtl/pfb_lane_sum.sv
module pfb_lane_sum #(
  parameter int TAPS  = 8,
  parameter int PRW   = 16,
  parameter int OW    = 18,
  parameter int SHIFT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TAPS*PRW-1:0]      prods,
  output logic signed [OW-1:0]     dout,
  output logic                     sat_hi,
  output logic                     sat_lo
);
  localparam int SW = PRW + $clog2(TAPS);
  localparam logic signed [SW:0] HALF = (SW+1)'((1 << SHIFT) >> 1);
  localparam logic signed [SW:0] MAXV = (SW+1)'((1 << (OW - 1)) - 1);
  localparam logic signed [SW:0] MINV = -(SW+1)'(1 << (OW - 1));

  function automatic logic signed [SW-1:0] sum_taps(input logic [TAPS*PRW-1:0] p);
    logic signed [SW-1:0]  acc;
    logic signed [PRW-1:0] term;
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      term = p[t*PRW +: PRW];
      acc  = acc + SW'(term);
    end
    return acc;
  endfunction

  function automatic logic signed [SW:0] round_half_up(input logic signed [SW-1:0] s);
    logic signed [SW:0] biased;
    biased = (SW+1)'(s) + HALF;
    return biased >>> SHIFT;
  endfunction

  logic signed [SW-1:0] total;
  logic signed [SW:0]   rounded;
  logic signed [OW-1:0] clipped;

  always_comb begin
    total   = sum_taps(prods);
    rounded = round_half_up(total);
    sat_hi  = rounded > MAXV;
    sat_lo  = rounded < MINV;
    if (sat_hi)      clipped = MAXV[OW-1:0];
    else if (sat_lo) clipped = MINV[OW-1:0];
    else             clipped = rounded[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= clipped;
  end
endmodule

// File: rtl/pfb_polyphase_fir.sv
module pfb_polyphase_fir #(
  parameter int N     = 32,
  parameter int TAPS  = 8,
  parameter int IW    = 8,
  parameter int CW    = 8,
  parameter int OW    = 18,
  parameter int SHIFT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_in,
  input  logic [2*IW-1:0] din_a,
  input  logic [2*IW-1:0] din_b,
  output logic            sync_out,
  output logic [2*OW-1:0] dout_a,
  output logic [2*OW-1:0] dout_b
);
  localparam int LANES = 4;                  // A re, A im, B re, B im
  localparam int WW    = LANES * IW;
  localparam int RW    = $clog2(N);
  localparam int ROM_D = TAPS * N;
  localparam int AW    = $clog2(ROM_D);
  localparam int PRW   = IW + CW;
  localparam int LAT   = 2;                  // product register + output register

  function automatic logic signed [PRW-1:0] mul(input logic signed [IW-1:0] x,
                                                input logic signed [CW-1:0] c);
    return PRW'(x) * PRW'(c);
  endfunction

  // ---------------- rotation index ----------------
  logic [RW-1:0] rot;
  logic          rot_wrap;
  assign rot_wrap = (rot == RW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rot <= '0;
    else if (sync_in || rot_wrap) rot <= '0;
    else                        rot <= rot + RW'(1);
  end

  // ---------------- coefficient ROM ----------------
  logic signed [CW-1:0] rom [ROM_D];
  for (genvar a = 0; a < ROM_D; a++) begin : g_rom
    assign rom[a] = CW'(pfb_pkg::coef_value(pfb_pkg::coef_arg(a, N), CW));
  end

  // ---------------- frame-spaced delay chain ----------------
  logic [WW-1:0] tap_word [TAPS];
  assign tap_word[0] = {din_a, din_b};

  for (genvar t = 1; t < TAPS; t++) begin : g_dly
    pfb_delay_line #(.W(WW), .DEPTH(N)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (tap_word[t-1]),
      .dout (tap_word[t])
    );
  end

  // ---------------- per-tap coefficient and products ----------------
  logic [TAPS*PRW-1:0] lane_prods [LANES];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [AW-1:0]        addr;
    logic signed [CW-1:0] coef;
    assign addr = AW'(t * N) + AW'(rot);
    assign coef = rom[addr];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [IW-1:0]  smp;
      logic signed [PRW-1:0] prod_q;
      assign smp = tap_word[t][(LANES-l)*IW-1 -: IW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= mul(smp, coef);
      end
      assign lane_prods[l][t*PRW +: PRW] = prod_q;
    end
  end

  // ---------------- lane sums, rounding, clipping ----------------
  logic signed [OW-1:0] lane_out [LANES];
  logic [LANES*OW-1:0]  lane_flat;
  logic [LANES-1:0]     sat_hi;
  logic [LANES-1:0]     sat_lo;

  for (genvar l = 0; l < LANES; l++) begin : g_sum
    pfb_lane_sum #(.TAPS(TAPS), .PRW(PRW), .OW(OW), .SHIFT(SHIFT)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .prods (lane_prods[l]),
      .dout  (lane_out[l]),
      .sat_hi(sat_hi[l]),
      .sat_lo(sat_lo[l])
    );
    assign lane_flat[l*OW +: OW] = lane_out[l];
  end

  assign dout_a = {lane_out[0], lane_out[1]};
  assign dout_b = {lane_out[2], lane_out[3]};

  // ---------------- sync alignment ----------------
  logic [LAT-1:0] sync_pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_pipe <= '0;
    else        sync_pipe <= {sync_pipe[LAT-2:0], sync_in};
  end
  assign sync_out = sync_pipe[LAT-1];
endmodule

// File: rtl/pfb_fir_chk.sv
module pfb_fir_chk #(
  parameter int N     = 32,
  parameter int LANES = 4,
  parameter int OW    = 18
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sync_in,
  input logic                  sync_out,
  input logic [$clog2(N)-1:0]  rot,
  input logic                  rot_wrap,
  input logic [LANES-1:0]      sat_hi,
  input logic [LANES-1:0]      sat_lo,
  input logic [LANES*OW-1:0]   lane_flat
);
  localparam int RW = $clog2(N);
  localparam logic [OW-1:0] TOP_V = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] BOT_V = {1'b1, {(OW-1){1'b0}}};

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (sync_out == $past(sync_in, 2)));

  assert_rot_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (rot == '0));

  assert_rot_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && rot_wrap) |=> (rot == '0));

  assert_rot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && !rot_wrap) |=> (rot == RW'($past(rot) + 1)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sat_hi[l] |=> (lane_flat[l*OW +: OW] == TOP_V));
    assert_clip_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sat_lo[l] |=> (lane_flat[l*OW +: OW] == BOT_V));
  end
endmodule

bind pfb_polyphase_fir pfb_fir_chk #(.N(N), .LANES(LANES), .OW(OW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_in  (sync_in),
  .sync_out (sync_out),
  .rot      (rot),
  .rot_wrap (rot_wrap),
  .sat_hi   (sat_hi),
  .sat_lo   (sat_lo),
  .lane_flat(lane_flat)
);

// File: tb/pfb_polyphase_fir_tb_top.sv
module pfb_polyphase_fir_tb_top;
  localparam int N    = 32;
  localparam int TAPS = 8;
  localparam int IW   = 8;
  localparam int OW   = 18;
  localparam int OWN  = 12;
  localparam int SH   = 1;
  localparam int HMAX = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic [2*IW-1:0] din_a = '0;
  logic [2*IW-1:0] din_b = '0;
  logic sync_out, sync_out_n;
  logic [2*OW-1:0]  dout_a, dout_b;
  logic [2*OWN-1:0] nout_a, nout_b;

  always #4 clk = ~clk;   // 125 MHz

  pfb_polyphase_fir dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .din_a(din_a), .din_b(din_b),
    .sync_out(sync_out), .dout_a(dout_a), .dout_b(dout_b));

  pfb_polyphase_fir #(.OW(OWN), .SHIFT(SH)) dut_narrow_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .din_a(din_a), .din_b(din_b),
    .sync_out(sync_out_n), .dout_a(nout_a), .dout_b(nout_b));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int hist [4][HMAX];
  int nsamp = 0;
  int mrot = 0;
  int unsigned seed = 32'h1234_5678;
  string cur_tag = "R9";

  int             q_due [$];
  string          q_tag [$];
  logic [2*OW-1:0]  q_ea [$];
  logic [2*OW-1:0]  q_eb [$];
  logic [2*OWN-1:0] q_na [$];
  logic [2*OWN-1:0] q_nb [$];
  logic           q_sy [$];

  function automatic int bcoef(input int t, input int r);
    int j;
    j = t * N + (N - 1 - r);
    return ((29 * j + 11) % 255) - 127;
  endfunction

  function automatic int bround(input longint s, input int ow);
    longint q;
    longint lim;
    q = longint'($floor(real'(s) / (2.0 ** SH) + 0.5));
    lim = longint'(1) << (ow - 1);
    if (q > lim - 1) q = lim - 1;
    if (q < -lim)    q = -lim;
    return int'(q);
  endfunction

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one sample per clock and predicts its filtered result.
  task automatic drive(input logic [7:0] ar, input logic [7:0] ai,
                       input logic [7:0] br, input logic [7:0] bi, input logic s);
    int e [4];
    int en [4];
    longint acc;
    din_a = {ar, ai};
    din_b = {br, bi};
    sync_in = s;
    if (nsamp < HMAX) begin
      hist[0][nsamp] = int'($signed(ar));
      hist[1][nsamp] = int'($signed(ai));
      hist[2][nsamp] = int'($signed(br));
      hist[3][nsamp] = int'($signed(bi));
    end
    for (int l = 0; l < 4; l++) begin
      acc = 0;
      for (int t = 0; t < TAPS; t++) begin
        if (nsamp >= t * N)
          acc += longint'(bcoef(t, mrot)) * longint'(hist[l][nsamp - t * N]);
      end
      e[l]  = bround(acc, OW);
      en[l] = bround(acc, OWN);
    end
    q_due.push_back(cyc + 2);
    q_tag.push_back(cur_tag);
    q_ea.push_back({OW'(e[0]), OW'(e[1])});
    q_eb.push_back({OW'(e[2]), OW'(e[3])});
    q_na.push_back({OWN'(en[0]), OWN'(en[1])});
    q_nb.push_back({OWN'(en[2]), OWN'(en[3])});
    q_sy.push_back(s);
    nsamp++;
    mrot = s ? 0 : (mrot + 1) % N;
    @(negedge clk);
  endtask

  // Monitor: compares each result in the clock it is due.
  always @(negedge clk) begin
    if (rst_n) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        check(q_tag[0], "dout_a",      64'(dout_a),     64'(q_ea[0]));
        check(q_tag[0], "dout_b",      64'(dout_b),     64'(q_eb[0]));
        check(q_tag[0], "narrow a",    64'(nout_a),     64'(q_na[0]));
        check(q_tag[0], "narrow b",    64'(nout_b),     64'(q_nb[0]));
        check("R8",     "sync_out",    64'(sync_out),   64'(q_sy[0]));
        check("R8",     "sync_out n",  64'(sync_out_n), 64'(q_sy[0]));
        void'(q_due.pop_front());
        void'(q_tag.pop_front());
        void'(q_ea.pop_front());
        void'(q_eb.pop_front());
        void'(q_na.pop_front());
        void'(q_nb.pop_front());
        void'(q_sy.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state, with activity on the inputs
    din_a = 16'h7f80; din_b = 16'h1234; sync_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "dout_a reset",   64'(dout_a),     64'd0);
    check("R9", "dout_b reset",   64'(dout_b),     64'd0);
    check("R9", "narrow reset",   64'(nout_a),     64'd0);
    check("R9", "sync_out reset", 64'(sync_out),   64'd0);
    check("R9", "sync_n reset",   64'(sync_out_n), 64'd0);
    rst_n = 1'b1;

    // R2 R3: impulse on stream A real reads out every tap and index
    cur_tag = "R2 R3";
    repeat (3) drive(8'd0, 8'd0, 8'd0, 8'd0, 1'b0);
    drive(8'd0, 8'd0, 8'd0, 8'd0, 1'b1);
    for (int k = 0; k < TAPS * N + 8; k++)
      drive((k == 0) ? 8'd100 : 8'd0, 8'd0, 8'd0, 8'd0, 1'b0);

    // R1 R5 R6: distinct random data on all four lanes
    cur_tag = "R1 R5 R6";
    for (int k = 0; k < 4 * N; k++)
      drive(rnd8(), rnd8(), rnd8(), rnd8(), 1'b0);

    // R4: sync repeated exactly on the frame boundary
    cur_tag = "R4";
    for (int k = 0; k < 4 * N; k++)
      drive(rnd8(), rnd8(), rnd8(), rnd8(), (mrot == N - 1));

    // R7 R6: full-scale inputs push the narrow build past both limits
    cur_tag = "R7 R6";
    for (int k = 0; k < 3 * N; k++)
      drive(8'h80, 8'h7f, k[0] ? 8'h80 : 8'h7f, 8'h80, 1'b0);

    // R10: sync in the middle of a frame realigns the rotation
    cur_tag = "R10";
    repeat (5) drive(rnd8(), rnd8(), rnd8(), rnd8(), 1'b0);
    drive(rnd8(), rnd8(), rnd8(), rnd8(), 1'b1);
    for (int k = 0; k < 2 * N; k++)
      drive(rnd8(), rnd8(), rnd8(), rnd8(), 1'b0);

    cur_tag = "R6";
    repeat (4) drive(8'd0, 8'd0, 8'd0, 8'd0, 1'b0);
    while (q_due.size() > 0) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule